// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It looks up a page table with two levels that sits in ordinary memory. The top 10 bits of the address pick an entry in the root table, and that entry points at a second-level table. The next 10 bits pick an entry in that table, and that entry holds the frame number. The low 12 bits pass through unchanged as the offset inside a 4 KB page.

A client offers a virtual address with a valid/ready handshake and later receives a single-cycle response. The response carries either the translated address or a fault code. Software programs the location of the root table and the number of usable root entries. The walker samples both values when it accepts a request. Both table reads go through a simple read port: a one-cycle request pulse, then a response of any latency.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0.
- R2: If the root index `req_vaddr[31:22]` is greater than or equal to `cfg_len`, the walk ends with fault code 1. No memory read is issued. A `cfg_len` of 0 rejects every address.
- R3: An accepted in-range request issues exactly one root read at `cfg_root + 4*req_vaddr[31:22]`.
- R4: A root entry with bit 0 clear ends the walk with fault code 2. No second read is issued.
- R5: A valid root entry leads to one second-level read at `{entry[31:12], 12'h000} + 4*req_vaddr[21:12]`.
- R6: A second-level entry with bit 0 clear ends the walk with fault code 3.
- R7: A valid second-level entry produces `rsp_paddr = {entry[31:12], req_vaddr[11:0]}` with `rsp_fault` at 0 and code 0. Bits 11:1 of either entry have no effect.
- R8: `rsp_valid` stays high for exactly one cycle per request. `req_ready` is high only while the walker is idle. `rsp_fault` is 1 exactly when `rsp_code` is nonzero.
- R9: Each read is a one-cycle `mem_req_valid` pulse. The walker waits any number of cycles for `mem_rsp_valid`.
- R10: `cfg_root` and `cfg_len` are sampled when a request is accepted. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 2 | 0 ok, 1 length, 2 root invalid, 3 leaf invalid |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| cfg_root | input | 32 | Byte address of the root table |
| cfg_len | input | 11 | Number of legal root entries |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The hardest case to reach from the ports is a configuration change that lands while a walk is in flight. Changing `cfg_root` and `cfg_len` between acceptance and the first read only matters if the walker keeps using the live values. To cover this, the bench perturbs both inputs right after the accepting edge and leaves them perturbed across both reads. It then checks the read addresses and the result against the values sampled at acceptance. The bench's memory model also returns data after a random delay and fills entry bits 11:1 with nonzero junk. This exercises wait states of different lengths and the masking of those bits.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int AW    = 32,
  parameter int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code,
  output logic [AW-1:0]    rsp_paddr,
  input  logic [AW-1:0]    cfg_root,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             mem_req_valid,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data
);
  localparam int PG_W = AW - OFF_W;
  localparam int PAD  = AW - IDX_W - 2;
  localparam logic [1:0] C_OK = 2'd0, C_LEN = 2'd1, C_ROOT = 2'd2, C_LEAF = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD_ROOT, S_WT_ROOT, S_RD_LEAF, S_WT_LEAF, S_DONE, S_FAULT} st_t;

  st_t              st;
  logic [AW-1:0]    va_q, addr_q;
  logic [PG_W-1:0]  frame_q;
  logic [1:0]       code_q;

  wire [IDX_W-1:0] hi_in  = req_vaddr[AW-1 -: IDX_W];
  wire [IDX_W-1:0] lo_idx = va_q[OFF_W +: IDX_W];
  wire             pte_ok = mem_rsp_data[0];
  wire [PG_W-1:0]  pte_pg = mem_rsp_data[AW-1:OFF_W];
  wire             unused_bits = ^mem_rsp_data[OFF_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      frame_q <= '0;
      code_q  <= C_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          if ({1'b0, hi_in} >= cfg_len) begin
            code_q <= C_LEN;
            st     <= S_FAULT;
          end else begin
            code_q <= C_OK;
            addr_q <= cfg_root + {{PAD{1'b0}}, hi_in, 2'b00};
            st     <= S_RD_ROOT;
          end
        end
        S_RD_ROOT: st <= S_WT_ROOT;
        S_WT_ROOT: if (mem_rsp_valid) begin
          if (!pte_ok) begin
            code_q <= C_ROOT;
            st     <= S_FAULT;
          end else begin
            addr_q <= {pte_pg, {OFF_W{1'b0}}} + {{PAD{1'b0}}, lo_idx, 2'b00};
            st     <= S_RD_LEAF;
          end
        end
        S_RD_LEAF: st <= S_WT_LEAF;
        S_WT_LEAF: if (mem_rsp_valid) begin
          if (!pte_ok) begin
            code_q <= C_LEAF;
            st     <= S_FAULT;
          end else begin
            frame_q <= pte_pg;
            st      <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD_ROOT) || (st == S_RD_LEAF);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (st == S_DONE) || (st == S_FAULT);
  assign rsp_fault     = (st == S_FAULT);
  assign rsp_code      = code_q;
  assign rsp_paddr     = (st == S_DONE) ? {frame_q, va_q[OFF_W-1:0]} : '0;
endmodule

module pt_walker_chk #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int AW    = 32,
  parameter int LEN_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [1:0]       rsp_code,
  input logic [AW-1:0]    rsp_paddr,
  input logic [AW-1:0]    cfg_root,
  input logic [LEN_W-1:0] cfg_len,
  input logic             mem_req_valid,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [AW-1:0]    mem_rsp_data
);
  localparam int PAD = AW - IDX_W - 2;
  wire [IDX_W-1:0] hi = req_vaddr[AW-1 -: IDX_W];
  wire accept = req_valid && req_ready;
  wire in_rng = ({1'b0, hi} < cfg_len);

  assert_len_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_rng |=> rsp_valid && rsp_fault && rsp_code == 2'd1);

  assert_root_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_rng |=> mem_req_valid &&
      mem_req_addr == $past(cfg_root) + {{PAD{1'b0}}, $past(hi), 2'b00});

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  assert_fault_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_code != 2'd0)));

  assert_mem_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
endmodule

bind pt_walker pt_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .AW(AW), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic [31:0] cfg_root = 32'h0000_8000;
  logic [10:0] cfg_len = 11'd1024;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, errors = 0, nreads = 0;
  logic [31:0] rd_addr[2];
  logic [31:0] tbl_root = 32'h0000_8000;
  bit finished = 0;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (.*);

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] oi, ii;
    if (a >= tbl_root && a < tbl_root + 32'h1000) begin
      oi = (a - tbl_root) >> 2;
      return {20'h00100 + oi[19:0], 11'h2A5, (oi % 5) != 3};
    end else if (a >= 32'h0010_0000 && a < 32'h0050_0000) begin
      oi = (a - 32'h0010_0000) >> 12;
      ii = (a >> 2) & 32'h3FF;
      return {20'((oi * 1237 + ii * 31 + 32'h300)), 11'h4C3, (ii % 7) != 2};
    end
    return 32'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        if (nreads < 2) rd_addr[nreads] = a;
        nreads++;
        repeat ($urandom_range(1, 4)) @(negedge clk);
        mem_rsp_data  = mem_word(a);
        mem_rsp_valid = 1;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(logic [31:0] va, logic [10:0] len, logic [31:0] root, bit perturb);
    logic [9:0]  hi, lo;
    logic [31:0] e1, e2, a1, a2, exp_pa;
    logic [1:0]  exp_code;
    int exp_reads;
    hi = va[31:22]; lo = va[21:12];
    tbl_root = root; cfg_root = root; cfg_len = len;
    a1 = root + {20'h0, hi, 2'b00};
    e1 = mem_word(a1);
    a2 = {e1[31:12], 12'h0} + {20'h0, lo, 2'b00};
    e2 = mem_word(a2);
    exp_pa = 32'h0;
    if ({1'b0, hi} >= len) begin exp_code = 2'd1; exp_reads = 0; end
    else if (!e1[0])       begin exp_code = 2'd2; exp_reads = 1; end
    else if (!e2[0])       begin exp_code = 2'd3; exp_reads = 2; end
    else begin exp_code = 2'd0; exp_reads = 2; exp_pa = {e2[31:12], va[11:0]}; end
    nreads = 0;
    @(negedge clk);
    req_vaddr = va; req_valid = 1;
    @(negedge clk);
    req_valid = 0; req_vaddr = $urandom;
    if (perturb) begin cfg_root = 32'h0030_0000; cfg_len = 11'd0; end
    for (int t = 0; t < 60 && !rsp_valid; t++) @(negedge clk);
    chk(rsp_valid, "R8 response", 32'(rsp_valid), 1);
    chk(rsp_code == exp_code, exp_code == 1 ? "R2 code" : exp_code == 2 ? "R4 code" :
        exp_code == 3 ? "R6 code" : "R7 code", 32'(rsp_code), 32'(exp_code));
    chk(rsp_fault == (exp_code != 0), "R8 fault flag", 32'(rsp_fault), 32'(exp_code != 0));
    chk(rsp_paddr == exp_pa, perturb ? "R10 paddr" : "R7 paddr", rsp_paddr, exp_pa);
    chk(nreads == exp_reads, "R9 read count", 32'(nreads), 32'(exp_reads));
    if (exp_reads >= 1) chk(rd_addr[0] == a1, perturb ? "R10 root addr" : "R3 root addr", rd_addr[0], a1);
    if (exp_reads >= 2) chk(rd_addr[1] == a2, "R5 leaf addr", rd_addr[1], a2);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 pulse and ready", {rsp_valid, req_ready}, 32'h1);
    cfg_root = root; cfg_len = len;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        {req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 after release",
        {req_ready, rsp_valid, mem_req_valid}, 32'h4);
    walk({10'd4, 10'd5, 12'h123}, 11'd1024, 32'h8000, 0);
    walk({10'd4, 10'd5, 12'h123}, 11'd0, 32'h8000, 0);
    walk({10'd5, 10'd1, 12'h000}, 11'd5, 32'h8000, 0);
    walk({10'd4, 10'd1, 12'hFFF}, 11'd5, 32'h8000, 0);
    walk({10'd1023, 10'd1023, 12'hABC}, 11'd1024, 32'h2000_0000, 0);
    walk({10'd3, 10'd0, 12'h010}, 11'd1024, 32'h8000, 0);
    walk({10'd6, 10'd2, 12'h010}, 11'd1024, 32'h8000, 0);
    walk({10'd7, 10'd9, 12'h777}, 11'd1024, 32'h8000, 1);
    walk({10'd8, 10'd11, 12'h321}, 11'd9, 32'h2000_0000, 1);
    for (int i = 0; i < 80; i++) begin
      logic [31:0] r;
      r = ($urandom % 2) ? 32'h8000 : 32'h2000_0000;
      walk($urandom, 11'($urandom_range(900, 1024)), r, ($urandom % 5) == 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule